// File: doc/BRIEF.md
# Dual-Host Configuration Register Bank

This block holds a small set of configuration parameters, such as an output swing setting or a spread depth, that two hosts can reach over one shared bank. One host arrives through a display auxiliary-channel side port. The other arrives through an I2C slave side port. Each port is a plain strobe bus with address, write data, a write strobe and a read strobe. The bit-level I2C serialiser and the auxiliary transaction decoder sit outside this block. They hand it decoded accesses, and the I2C side also hands over the received 7-bit device address.

Each parameter has a strap input. Until a host writes the parameter, the value driven on `param_o` is the strap value, zero-extended. After the first write, the register value drives `param_o`, and the strap is ignored until the next reset. The two hosts are ignored until the hot-plug-detect input has been seen high. The I2C side is also ignored in the low-power state. Both sides are ignored in the deep power-saving state. The I2C device address follows a select pin.

Top module: `dual_host_cfg_bank`

## Requirements
- R1: While reset is held and after it is released, every parameter is unwritten, `param_o` equals the zero-extended straps, and both ports' `ack` and `rvalid` outputs are low.
- R2: An unwritten parameter k drives `param_o[8k+7:8k]` with strap bits `straps_i[3k+2:3k]` zero-extended, and it follows those strap bits whenever they change.
- R3: An accepted write to parameter k's address drives the written byte on `param_o` from the cycle after the write. The parameter then keeps that byte, whatever the strap does, until the next accepted write to it.
- R4: An accepted read in cycle N raises that port's `rvalid` in cycle N+1 only, and `rdata` then holds the parameter's value as it stood before any write in cycle N.
- R5: Parameter k is at address 0x10+k for k from 0 to 3. A read of any other address returns 0x00, and a write to any other address changes nothing. Both are still acknowledged.
- R6: No access is accepted until `hpd_i` has been sampled high since reset; until then no write lands and no `ack` or `rvalid` appears. Once `hpd_i` has been seen high, accesses stay enabled even if it falls.
- R7: With `addr_sel_i` high (pin open), the I2C port answers only to 7-bit device address 0x60 (8-bit form 0xC0). With it low, the port answers only to 0x20 (8-bit form 0x40). An access to any other device address is ignored.
- R8: While `low_pwr_i` is high, I2C accesses are ignored and auxiliary accesses still work. While `deep_pd_i` is high, both ports are ignored.
- R9: When both ports write the same address in one cycle, the auxiliary byte is stored and the I2C write is dropped. Writes from the two ports to different addresses in one cycle both land.
- R10: An accepted read or write strobe in cycle N raises that port's `ack` in cycle N+1 only. A strobe that is not accepted raises no `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hpd_i | input | 1 | Hot-plug-detect level; enables access once seen high |
| low_pwr_i | input | 1 | Low-power state; disables the I2C port |
| deep_pd_i | input | 1 | Deep power-saving state; disables both ports |
| addr_sel_i | input | 1 | I2C address select: 1 = open (0x60), 0 = low (0x20) |
| straps_i | input | 12 | Strap values, 3 bits per parameter |
| aux_wr_i | input | 1 | Auxiliary-side write strobe |
| aux_rd_i | input | 1 | Auxiliary-side read strobe |
| aux_addr_i | input | 8 | Auxiliary-side register address |
| aux_wdata_i | input | 8 | Auxiliary-side write data |
| aux_ack_o | output | 1 | Auxiliary-side access accepted (one cycle later) |
| aux_rvalid_o | output | 1 | Auxiliary-side read data valid |
| aux_rdata_o | output | 8 | Auxiliary-side read data |
| i2c_dev_i | input | 7 | 7-bit device address received by the serialiser |
| i2c_wr_i | input | 1 | I2C-side write strobe |
| i2c_rd_i | input | 1 | I2C-side read strobe |
| i2c_addr_i | input | 8 | I2C-side register address |
| i2c_wdata_i | input | 8 | I2C-side write data |
| i2c_ack_o | output | 1 | I2C-side access accepted (one cycle later) |
| i2c_rvalid_o | output | 1 | I2C-side read data valid |
| i2c_rdata_o | output | 8 | I2C-side read data |
| param_o | output | 32 | Effective parameter values, 8 bits each |

## Verification
Some rules are checked by assertions on every cycle:
- the written flag never clears, and a written parameter holds still when no write hits it;
- a same-address collision stores the auxiliary byte;
- no `ack` or `rvalid` appears before hot-plug detect, under a disabled port, or for a wrong device address;
- a read of an unmapped address returns zero.

Other behaviour only the bench's scenarios can show. These are strap tracking before the first write and the switch to the register value after it, read-before-write ordering in one cycle, and the two select-pin addresses. A long random mix of both hosts, power states and strap changes is compared against a bench model.

// File: rtl/dhcfg_pkg.sv
package dhcfg_pkg;
  localparam int CFG_AW   = 8;
  localparam int CFG_DW   = 8;
  localparam int CFG_DEVW = 7;

  typedef struct packed {
    logic              we;
    logic [CFG_AW-1:0] addr;
    logic [CFG_DW-1:0] data;
  } wr_bus_t;
endpackage

// File: rtl/dhcfg_host_gate.sv
module dhcfg_host_gate #(
  parameter bit CHECK_DEV = 1'b0,
  parameter int DEVW      = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_en_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [DEVW-1:0] dev_i,
  input  logic [DEVW-1:0] dev_match_i,
  output logic            wr_ok_o,
  output logic            rd_ok_o,
  output logic            ack_o
);
  logic dev_hit;
  logic accept;
  logic ack_d, ack_q;

  always_comb begin
    dev_hit = (!CHECK_DEV) || (dev_i == dev_match_i);
    accept  = port_en_i && dev_hit;
    wr_ok_o = accept && wr_i;
    rd_ok_o = accept && rd_i;
    ack_d   = accept && (wr_i || rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign ack_o = ack_q;

  // R10: an ack always follows an enabled strobe
  p_ack_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(port_en_i && (wr_i || rd_i)));

  // R8: a disabled port never acknowledges
  p_blocked_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en_i |=> !ack_o);

  // R7: wrong device address gets no ack
  p_dev_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (CHECK_DEV && (dev_i != dev_match_i)) |=> !ack_o);
endmodule

// File: rtl/dhcfg_reg_slot.sv
module dhcfg_reg_slot
  import dhcfg_pkg::*;
#(
  parameter int                STRAP_W   = 3,
  parameter logic [CFG_AW-1:0] SLOT_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  wr_bus_t            aux_wr_i,
  input  wr_bus_t            i2c_wr_i,
  output logic [CFG_DW-1:0]  eff_o
);
  logic              aux_hit, i2c_hit;
  logic              upd_en;
  logic [CFG_DW-1:0] val_d, val_q;
  logic              written_d, written_q;

  always_comb begin
    aux_hit = aux_wr_i.we && (aux_wr_i.addr == SLOT_ADDR);
    i2c_hit = i2c_wr_i.we && (i2c_wr_i.addr == SLOT_ADDR);
    upd_en  = 1'b0;
    val_d   = val_q;
    if (aux_hit) begin
      upd_en = 1'b1;
      val_d  = aux_wr_i.data;
    end else if (i2c_hit) begin
      upd_en = 1'b1;
      val_d  = i2c_wr_i.data;
    end
    written_d = written_q || upd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q     <= '0;
      written_q <= 1'b0;
    end else if (upd_en) begin
      val_q     <= val_d;
      written_q <= written_d;
    end
  end

  assign eff_o = written_q ? val_q : CFG_DW'(strap_i);

  // R3: once written, a parameter stays on its register value
  p_written_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    written_q |=> written_q);

  // R3: no write, no change, whatever the strap does
  p_hold_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (written_q && !(aux_wr_i.we && aux_wr_i.addr == SLOT_ADDR)
               && !(i2c_wr_i.we && i2c_wr_i.addr == SLOT_ADDR))
    |=> $stable(eff_o));

  // R9: same-address collision keeps the auxiliary byte
  p_aux_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_wr_i.we && i2c_wr_i.we && aux_wr_i.addr == SLOT_ADDR &&
     i2c_wr_i.addr == SLOT_ADDR) |=> (eff_o == $past(aux_wr_i.data)));
endmodule

// File: rtl/dhcfg_read_port.sv
module dhcfg_read_port
  import dhcfg_pkg::*;
#(
  parameter int                NUM_REGS  = 4,
  parameter logic [CFG_AW-1:0] BASE_ADDR = 8'h10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_ok_i,
  input  logic [CFG_AW-1:0]          addr_i,
  input  logic [NUM_REGS*CFG_DW-1:0] eff_i,
  output logic                       rvalid_o,
  output logic [CFG_DW-1:0]          rdata_o
);
  logic [CFG_AW-1:0] offs;
  logic              hit;
  logic [CFG_DW-1:0] sel;
  logic              rvalid_d, rvalid_q;
  logic [CFG_DW-1:0] rdata_d, rdata_q;

  always_comb begin
    offs = addr_i - BASE_ADDR;
    hit  = (addr_i >= BASE_ADDR) && (offs < CFG_AW'(NUM_REGS));
    sel  = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (offs == CFG_AW'(i)) sel = eff_i[i*CFG_DW +: CFG_DW];
    end
    rvalid_d = rd_ok_i;
    rdata_d  = hit ? sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rvalid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_ok_i) rdata_q <= rdata_d;
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  // R4: data valid only after an accepted read strobe
  p_rvalid_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> $past(rd_ok_i));

  // R5: unmapped reads return zero
  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok_i && !((int'(addr_i) >= int'(BASE_ADDR)) &&
                  (int'(addr_i) < int'(BASE_ADDR) + NUM_REGS)))
    |=> (rdata_o == '0));
endmodule

// File: rtl/dual_host_cfg_bank.sv
module dual_host_cfg_bank
  import dhcfg_pkg::*;
#(
  parameter int                  NUM_REGS      = 4,
  parameter int                  STRAP_W       = 3,
  parameter logic [CFG_AW-1:0]   BASE_ADDR     = 8'h10,
  parameter logic [CFG_DEVW-1:0] I2C_DEV_OPEN  = 7'h60,
  parameter logic [CFG_DEVW-1:0] I2C_DEV_LOW   = 7'h20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hpd_i,
  input  logic                         low_pwr_i,
  input  logic                         deep_pd_i,
  input  logic                         addr_sel_i,
  input  logic [NUM_REGS*STRAP_W-1:0]  straps_i,
  input  logic                         aux_wr_i,
  input  logic                         aux_rd_i,
  input  logic [CFG_AW-1:0]            aux_addr_i,
  input  logic [CFG_DW-1:0]            aux_wdata_i,
  output logic                         aux_ack_o,
  output logic                         aux_rvalid_o,
  output logic [CFG_DW-1:0]            aux_rdata_o,
  input  logic [CFG_DEVW-1:0]          i2c_dev_i,
  input  logic                         i2c_wr_i,
  input  logic                         i2c_rd_i,
  input  logic [CFG_AW-1:0]            i2c_addr_i,
  input  logic [CFG_DW-1:0]            i2c_wdata_i,
  output logic                         i2c_ack_o,
  output logic                         i2c_rvalid_o,
  output logic [CFG_DW-1:0]            i2c_rdata_o,
  output logic [NUM_REGS*CFG_DW-1:0]   param_o
);
  localparam int EFF_W = NUM_REGS * CFG_DW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // hot-plug arming
  logic armed_d, armed_q;
  logic access_ok, aux_en, i2c_en;
  logic [CFG_DEVW-1:0] dev_sel;

  always_comb begin
    armed_d   = armed_q || hpd_i;
    access_ok = armed_q || hpd_i;
    aux_en    = access_ok && !deep_pd_i;
    i2c_en    = aux_en && !low_pwr_i;
    dev_sel   = addr_sel_i ? I2C_DEV_OPEN : I2C_DEV_LOW;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  armed_q <= 1'b0;
    else if (hpd_i)  armed_q <= armed_d;
  end

  // port qualification
  logic aux_wr_ok, aux_rd_ok, i2c_wr_ok, i2c_rd_ok;

  dhcfg_host_gate #(.CHECK_DEV(1'b0), .DEVW(CFG_DEVW)) aux_gate_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .port_en_i   (aux_en),
    .wr_i        (aux_wr_i),
    .rd_i        (aux_rd_i),
    .dev_i       ('0),
    .dev_match_i ('0),
    .wr_ok_o     (aux_wr_ok),
    .rd_ok_o     (aux_rd_ok),
    .ack_o       (aux_ack_o)
  );

  dhcfg_host_gate #(.CHECK_DEV(1'b1), .DEVW(CFG_DEVW)) i2c_gate_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .port_en_i   (i2c_en),
    .wr_i        (i2c_wr_i),
    .rd_i        (i2c_rd_i),
    .dev_i       (i2c_dev_i),
    .dev_match_i (dev_sel),
    .wr_ok_o     (i2c_wr_ok),
    .rd_ok_o     (i2c_rd_ok),
    .ack_o       (i2c_ack_o)
  );

  wr_bus_t aux_bus, i2c_bus;

  always_comb begin
    aux_bus.we   = aux_wr_ok;
    aux_bus.addr = aux_addr_i;
    aux_bus.data = aux_wdata_i;
    i2c_bus.we   = i2c_wr_ok;
    i2c_bus.addr = i2c_addr_i;
    i2c_bus.data = i2c_wdata_i;
  end

  // parameter registers
  logic [EFF_W-1:0] eff;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    dhcfg_reg_slot #(
      .STRAP_W   (STRAP_W),
      .SLOT_ADDR (CFG_AW'(int'(BASE_ADDR) + g))
    ) slot_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .strap_i  (straps_i[g*STRAP_W +: STRAP_W]),
      .aux_wr_i (aux_bus),
      .i2c_wr_i (i2c_bus),
      .eff_o    (eff[g*CFG_DW +: CFG_DW])
    );
  end

  assign param_o = eff;

  // read return paths
  dhcfg_read_port #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) aux_rd_i0 (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_ok_i  (aux_rd_ok),
    .addr_i   (aux_addr_i),
    .eff_i    (eff),
    .rvalid_o (aux_rvalid_o),
    .rdata_o  (aux_rdata_o)
  );

  dhcfg_read_port #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) i2c_rd_i0 (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_ok_i  (i2c_rd_ok),
    .addr_i   (i2c_addr_i),
    .eff_i    (eff),
    .rvalid_o (i2c_rvalid_o),
    .rdata_o  (i2c_rdata_o)
  );

  // R6: arming never drops before reset
  p_armed_sticky_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    armed_q |=> armed_q);

  // R6: nothing is accepted before hot-plug detect
  p_no_access_before_hpd_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!armed_q && !hpd_i) |=>
      (!aux_ack_o && !i2c_ack_o && !aux_rvalid_o && !i2c_rvalid_o));

  // R8: deep power-saving silences both ports
  p_deep_pd_silent_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    deep_pd_i |=> (!aux_ack_o && !i2c_ack_o));
endmodule

// File: tb/dual_host_cfg_bank_tb_top.sv
module dual_host_cfg_bank_tb_top;
  localparam int N  = 4;
  localparam int SW = 3;
  localparam logic [7:0] BASE = 8'h10;

  logic clk = 1'b0;
  logic rst_n;
  logic hpd, lowp, deep, asel;
  logic [N*SW-1:0] straps;
  logic aux_wr, aux_rd;
  logic [7:0] aux_addr, aux_wdata;
  logic aux_ack, aux_rvalid;
  logic [7:0] aux_rdata;
  logic [6:0] i2c_dev;
  logic i2c_wr, i2c_rd;
  logic [7:0] i2c_addr, i2c_wdata;
  logic i2c_ack, i2c_rvalid;
  logic [7:0] i2c_rdata;
  logic [N*8-1:0] param;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_val [N];
  bit         m_wr  [N];
  bit         m_armed;

  always #5 clk = ~clk;

  dual_host_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .hpd_i(hpd), .low_pwr_i(lowp), .deep_pd_i(deep),
    .addr_sel_i(asel), .straps_i(straps),
    .aux_wr_i(aux_wr), .aux_rd_i(aux_rd), .aux_addr_i(aux_addr), .aux_wdata_i(aux_wdata),
    .aux_ack_o(aux_ack), .aux_rvalid_o(aux_rvalid), .aux_rdata_o(aux_rdata),
    .i2c_dev_i(i2c_dev), .i2c_wr_i(i2c_wr), .i2c_rd_i(i2c_rd), .i2c_addr_i(i2c_addr),
    .i2c_wdata_i(i2c_wdata), .i2c_ack_o(i2c_ack), .i2c_rvalid_o(i2c_rvalid),
    .i2c_rdata_o(i2c_rdata), .param_o(param)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] eff(input int k);
    return m_wr[k] ? m_val[k] : {5'b0, straps[k*SW +: SW]};
  endfunction

  function automatic bit mapped(input logic [7:0] a);
    return (a >= BASE) && (a < BASE + 8'(N));
  endfunction

  function automatic logic [7:0] rd_exp(input logic [7:0] a);
    return mapped(a) ? eff(int'(a - BASE)) : 8'h00;
  endfunction

  task automatic set_aux(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d);
    aux_wr = w; aux_rd = r; aux_addr = a; aux_wdata = d;
  endtask

  task automatic set_i2c(input logic [6:0] dv, input bit w, input bit r,
                         input logic [7:0] a, input logic [7:0] d);
    i2c_dev = dv; i2c_wr = w; i2c_rd = r; i2c_addr = a; i2c_wdata = d;
  endtask

  // one clock with the model as oracle; inputs set before the call
  task automatic step();
    bit acc, aux_ok, i2c_ok, e_aack, e_arv, e_iack, e_irv;
    logic [7:0] e_ard, e_ird;
    acc    = m_armed || hpd;
    aux_ok = acc && !deep;
    i2c_ok = aux_ok && !lowp && (i2c_dev == (asel ? 7'h60 : 7'h20));
    e_aack = aux_ok && (aux_wr || aux_rd);
    e_arv  = aux_ok && aux_rd;
    e_ard  = rd_exp(aux_addr);
    e_iack = i2c_ok && (i2c_wr || i2c_rd);
    e_irv  = i2c_ok && i2c_rd;
    e_ird  = rd_exp(i2c_addr);
    if (i2c_ok && i2c_wr && mapped(i2c_addr) &&
        !(aux_ok && aux_wr && aux_addr == i2c_addr)) begin
      m_val[int'(i2c_addr - BASE)] = i2c_wdata;
      m_wr[int'(i2c_addr - BASE)]  = 1'b1;
    end
    if (aux_ok && aux_wr && mapped(aux_addr)) begin
      m_val[int'(aux_addr - BASE)] = aux_wdata;
      m_wr[int'(aux_addr - BASE)]  = 1'b1;
    end
    m_armed = m_armed || hpd;
    @(negedge clk);
    chk("R10 aux ack", 32'(aux_ack), 32'(e_aack));
    chk("R10 i2c ack", 32'(i2c_ack), 32'(e_iack));
    chk("R4 aux rvalid", 32'(aux_rvalid), 32'(e_arv));
    chk("R4 i2c rvalid", 32'(i2c_rvalid), 32'(e_irv));
    if (e_arv) chk("R4 aux rdata", 32'(aux_rdata), 32'(e_ard));
    if (e_irv) chk("R4 i2c rdata", 32'(i2c_rdata), 32'(e_ird));
    for (int k = 0; k < N; k++)
      chk(m_wr[k] ? "R3 param" : "R2 param", 32'(param[k*8 +: 8]), 32'(eff(k)));
    set_aux(0, 0, aux_addr, aux_wdata);
    set_i2c(i2c_dev, 0, 0, i2c_addr, i2c_wdata);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; hpd = 0; lowp = 0; deep = 0; asel = 1;
    straps = 12'h5A3;
    set_aux(0, 0, 8'h00, 8'h00);
    set_i2c(7'h60, 0, 0, 8'h00, 8'h00);
    for (int k = 0; k < N; k++) begin m_val[k] = 8'h00; m_wr[k] = 1'b0; end
    m_armed = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 param in reset", 32'(param), {8'h0, 8'h02, 8'h06, 8'h04, 8'h03} [31:0]);
    chk("R1 ack in reset", 32'({aux_ack, i2c_ack, aux_rvalid, i2c_rvalid}), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 param after reset", 32'(param), 32'h02060403);

    // R6: before hot-plug nothing lands
    set_aux(1, 0, 8'h10, 8'hAA); step();
    chk("R6 write before hpd", 32'(param[7:0]), 32'h03);
    set_aux(0, 1, 8'h10, 8'h00); step();
    chk("R6 read before hpd", 32'(aux_rvalid), 32'h0);

    // R6: one high pulse arms permanently
    hpd = 1; step(); hpd = 0;
    set_aux(1, 0, 8'h10, 8'h5A); step();
    chk("R3 write lands", 32'(param[7:0]), 32'h5A);
    straps = 12'h000; step();
    chk("R3 strap ignored after write", 32'(param[7:0]), 32'h5A);
    chk("R2 strap tracked", 32'(param[15:8]), 32'h00);
    straps = 12'hFFF; step();
    chk("R2 strap tracked high", 32'(param[15:8]), 32'h07);

    // R5: unmapped addresses
    set_aux(1, 0, 8'h20, 8'hFF); step();
    chk("R5 unmapped write ack", 32'(aux_ack), 32'h1);
    set_aux(1, 0, 8'h0F, 8'hFF); step();
    set_aux(0, 1, 8'h20, 8'h00); step();
    chk("R5 unmapped read", 32'(aux_rdata), 32'h00);
    chk("R5 map unchanged", 32'(param), 32'h0707075A);

    // R7: device address select
    set_i2c(7'h60, 1, 0, 8'h11, 8'h33); step();
    chk("R7 open address ack", 32'(i2c_ack), 32'h1);
    chk("R7 open address write", 32'(param[15:8]), 32'h33);
    set_i2c(7'h20, 1, 0, 8'h11, 8'h44); step();
    chk("R7 wrong address ignored", 32'(param[15:8]), 32'h33);
    asel = 0;
    set_i2c(7'h20, 1, 0, 8'h11, 8'h44); step();
    chk("R7 low address write", 32'(param[15:8]), 32'h44);
    set_i2c(7'h60, 0, 1, 8'h11, 8'h00); step();
    chk("R7 open address now ignored", 32'(i2c_rvalid), 32'h0);

    // R8: power states
    lowp = 1;
    set_i2c(7'h20, 1, 0, 8'h12, 8'h99);
    set_aux(1, 0, 8'h13, 8'h77); step();
    chk("R8 low-power i2c ignored", 32'(param[23:16]), 32'h07);
    chk("R8 low-power aux works", 32'(param[31:24]), 32'h77);
    lowp = 0; deep = 1;
    set_aux(1, 0, 8'h13, 8'h11); step();
    chk("R8 deep aux ignored", 32'(param[31:24]), 32'h77);
    deep = 0;

    // R9: collisions
    set_aux(1, 0, 8'h12, 8'hA1);
    set_i2c(7'h20, 1, 0, 8'h12, 8'hB2); step();
    chk("R9 aux wins", 32'(param[23:16]), 32'hA1);
    set_aux(1, 0, 8'h10, 8'hC3);
    set_i2c(7'h20, 1, 0, 8'h13, 8'hD4); step();
    chk("R9 both land", 32'({param[31:24], param[7:0]}), 32'hD4C3);

    // R4: read and write to one address in one cycle returns old value
    set_aux(1, 0, 8'h10, 8'hE5);
    set_i2c(7'h20, 0, 1, 8'h10, 8'h00); step();
    chk("R4 read before write", 32'(i2c_rdata), 32'hC3);
    chk("R10 ack single cycle pre", 32'(aux_ack), 32'h1);
    step();
    chk("R10 ack single cycle", 32'(aux_ack), 32'h0);

    // random mix
    for (int t = 0; t < 4000; t++) begin
      logic [7:0] ra, ia;
      ra = ($urandom % 4 == 0) ? 8'($urandom) : BASE + 8'($urandom % N);
      ia = ($urandom % 4 == 0) ? 8'($urandom) : BASE + 8'($urandom % N);
      lowp = ($urandom % 8 == 0);
      deep = ($urandom % 16 == 0);
      if ($urandom % 50 == 0) asel = ~asel;
      if ($urandom % 20 == 0) straps = 12'($urandom);
      case ($urandom % 3)
        0: set_aux(1, 0, ra, 8'($urandom));
        1: set_aux(0, 1, ra, 8'h00);
        default: set_aux(0, 0, ra, 8'h00);
      endcase
      case ($urandom % 3)
        0: set_i2c(($urandom % 4 == 0) ? 7'($urandom) : (asel ? 7'h60 : 7'h20), 1, 0, ia, 8'($urandom));
        1: set_i2c(asel ? 7'h60 : 7'h20, 0, 1, ia, 8'h00);
        default: set_i2c(i2c_dev, 0, 0, ia, 8'h00);
      endcase
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule